// File: doc/BRIEF.md
# Kernel Run Sequencer

This block sits between a simple register port and the start/ready/done/idle handshake of a streaming compute kernel. It decides when the kernel begins each run, so that software does not have to issue a start for every run. Software writes a run count into a count register. A value of N asks for exactly N back-to-back runs. The all-ones value asks for runs that repeat until they are cancelled. Writing zero cancels any launches still pending. A run that is already in flight is allowed to finish.

A control register reports whether launches are pending, whether the sequencer is quiet, and a sticky completion flag. In count mode this flag rises once, after the final run has finished and the kernel is idle. A read of the control register clears it. The control register also keeps an older per-run style. In that style, setting the auto bit together with the go bit makes the kernel restart after every run, and the completion flag is raised after each run. Setting only the go bit requests a single run.

Each launch is a one-cycle start pulse. No further pulse is issued until the kernel acknowledges the run with ready.

Top module: `krc_top`

## Requirements
- R1: After reset, k_start is low, the count register reads 0, and the control register reads 0x04 (quiet bit set, all other bits clear).
- R2: Writing a count N (neither zero nor all ones) at byte address 0x10 produces exactly N start pulses. The register drops by one at each launch and reads back the number of launches still owed.
- R3: Writing all ones to the count register makes the kernel run continuously. The register keeps reading all ones.
- R4: Writing zero to the count register stops all further launches and the register reads 0. A run already started still completes, and the completion flag rises after it.
- R5: In count mode and single-run mode, the completion flag (control bit 1) rises only after the last run's done and with the kernel idle. It never rises after an earlier run of the same sequence.
- R6: The completion flag stays set until a read of the control register (byte address 0x00). When a read and a new completion fall in the same cycle, the read returns the old value and the flag ends up set.
- R7: Each start pulse lasts exactly one cycle. After a pulse, no further pulse is issued until k_ready has been seen.
- R8: Writing the control register with bit 7 (auto) and bit 0 (go) both set makes the kernel restart after every run, with the completion flag raised after each run. Writing 0x00 to the control register stops further launches.
- R9: Writing the control register with bit 0 set and bit 7 clear gives exactly one run, followed by the completion flag.
- R10: Control register layout: bit 0 = launches pending, bit 1 = completion flag, bit 2 = quiet (nothing pending, unacknowledged or in flight), bit 7 = auto bit as last written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears the next cycle |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| k_start | output | 1 | One-cycle run start pulse to the kernel |
| k_ready | input | 1 | Kernel has accepted the run |
| k_done | input | 1 | Kernel has finished a run |
| k_idle | input | 1 | Kernel is idle |

## Verification
The completion flag can be set by a finishing sequence and cleared by a host read of the control register in the same cycle. The bench watches the final run's done pulse. From that pulse it works out the exact cycle in which the sequencer recognises completion, and it places a control read in that cycle. The read must return the flag clear, and a second read must return it set, which shows that the new event survived the clear.

// File: rtl/krc_pkg.sv
package krc_pkg;
  localparam int unsigned CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t FOREVER = '1;

  localparam int unsigned CB_ACTIVE = 0;
  localparam int unsigned CB_DONE   = 1;
  localparam int unsigned CB_IDLE   = 2;
  localparam int unsigned CB_AUTO   = 7;

  // true when the count value is a finite run budget
  function automatic logic cnt_is_finite(cnt_t c);
    return (c != '0) && (c != FOREVER);
  endfunction

  // count value after one launch
  function automatic cnt_t cnt_after_launch(cnt_t c);
    return cnt_is_finite(c) ? c - 1'b1 : c;
  endfunction

  function automatic cnt_t pack_ctrl(logic act, logic dn, logic qt, logic au);
    cnt_t v;
    v = '0;
    v[CB_ACTIVE] = act;
    v[CB_DONE]   = dn;
    v[CB_IDLE]   = qt;
    v[CB_AUTO]   = au;
    return v;
  endfunction
endpackage

// File: rtl/krc_regs.sv
module krc_regs
  import krc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = '0,
  parameter logic [AW-1:0] CNT_ADDR  = AW'(16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  cnt_t          reg_wdata,
  input  logic          st_active,
  input  logic          st_done,
  input  logic          st_quiet,
  input  cnt_t          st_cnt,
  output logic          ctrl_wr,
  output logic          cnt_wr,
  output logic          ctrl_rd,
  output logic          auto_en,
  output cnt_t          reg_rdata
);
  logic ctrl_sel, cnt_sel;
  assign ctrl_sel = (reg_addr == CTRL_ADDR);
  assign cnt_sel  = (reg_addr == CNT_ADDR);
  assign ctrl_wr  = reg_wr && ctrl_sel;
  assign cnt_wr   = reg_wr && cnt_sel;
  assign ctrl_rd  = reg_rd && ctrl_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       auto_en <= 1'b0;
    else if (ctrl_wr) auto_en <= reg_wdata[CB_AUTO];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (ctrl_sel)     reg_rdata <= pack_ctrl(st_active, st_done, st_quiet, auto_en);
      else if (cnt_sel) reg_rdata <= st_cnt;
      else              reg_rdata <= '0;
    end
  end

  // R10: auto bit follows the last control write
  a_r10_auto_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (auto_en == $past(reg_wdata[CB_AUTO])));
endmodule

// File: rtl/krc_launcher.sv
module krc_launcher
  import krc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_wr,
  input  logic ctrl_wr,
  input  logic go_bit,
  input  cnt_t wdata,
  input  logic auto_en,
  input  logic k_ready,
  output logic launch,
  output cnt_t cnt,
  output logic leg_go,
  output logic await_ack
);
  logic from_cnt;
  assign from_cnt = (cnt != '0);
  assign launch   = !await_ack && (from_cnt || leg_go);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= wdata;
    else if (launch) cnt <= cnt_after_launch(cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    leg_go <= 1'b0;
    else if (ctrl_wr)                              leg_go <= go_bit;
    else if (launch && !from_cnt && !auto_en)      leg_go <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       await_ack <= 1'b0;
    else if (launch)  await_ack <= 1'b1;
    else if (k_ready) await_ack <= 1'b0;
  end

  a_r7_one_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
  a_r7_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (await_ack && !k_ready) |=> !launch);
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cnt_is_finite(cnt) && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1));
  a_r3_forever_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FOREVER && !cnt_wr) |=> (cnt == FOREVER));
  a_r4_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && wdata == '0) |=> (cnt == '0));
endmodule

// File: rtl/krc_tracker.sv
module krc_tracker #(
  parameter int unsigned OUTW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic k_done,
  input  logic k_idle,
  input  logic seq_set,
  input  logic cnt_zero,
  input  logic leg_go,
  input  logic await_ack,
  input  logic auto_en,
  input  logic ctrl_rd,
  output logic done,
  output logic quiet,
  output logic done_evt
);
  localparam logic [OUTW-1:0] OUT_MAX = '1;
  logic [OUTW-1:0] outst;
  logic seq_act, seq_done_evt, leg_done_evt, ret;

  assign ret          = k_done && (outst != '0);
  assign quiet        = cnt_zero && !leg_go && !await_ack && (outst == '0);
  assign seq_done_evt = seq_act && quiet && k_idle && !seq_set;
  assign leg_done_evt = auto_en && ret;
  assign done_evt     = seq_done_evt || leg_done_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else case ({launch, ret})
      2'b10:   outst <= outst + 1'b1;
      2'b01:   outst <= outst - 1'b1;
      default: outst <= outst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            seq_act <= 1'b0;
    else if (seq_set)      seq_act <= 1'b1;
    else if (seq_done_evt) seq_act <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b0;
    else if (done_evt) done <= 1'b1;
    else if (ctrl_rd)  done <= 1'b0;
  end

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !done_evt) |=> !done);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && !ret && outst == OUT_MAX));
endmodule

// File: rtl/krc_top.sv
module krc_top
  import krc_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned OUTW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          k_start,
  input  logic          k_ready,
  input  logic          k_done,
  input  logic          k_idle
);
  logic ctrl_wr, cnt_wr, ctrl_rd, auto_en;
  logic launch, leg_go, await_ack, done, quiet, done_evt, seq_set;
  cnt_t cnt;

  assign seq_set = (cnt_wr && reg_wdata != '0) ||
                   (ctrl_wr && reg_wdata[CB_ACTIVE] && !reg_wdata[CB_AUTO]);
  assign k_start = launch;

  krc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .st_active((cnt != '0) || leg_go), .st_done(done), .st_quiet(quiet),
    .st_cnt(cnt), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .ctrl_rd(ctrl_rd),
    .auto_en(auto_en), .reg_rdata(reg_rdata)
  );

  krc_launcher u_launch (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
    .go_bit(reg_wdata[CB_ACTIVE]), .wdata(reg_wdata), .auto_en(auto_en),
    .k_ready(k_ready), .launch(launch), .cnt(cnt), .leg_go(leg_go),
    .await_ack(await_ack)
  );

  krc_tracker #(.OUTW(OUTW)) u_track (
    .clk(clk), .rst_n(rst_n), .launch(launch), .k_done(k_done),
    .k_idle(k_idle), .seq_set(seq_set), .cnt_zero(cnt == '0),
    .leg_go(leg_go), .await_ack(await_ack), .auto_en(auto_en),
    .ctrl_rd(ctrl_rd), .done(done), .quiet(quiet), .done_evt(done_evt)
  );

  // R5: completion outside auto mode only with an idle kernel and nothing owed
  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(auto_en)) |-> ($past(k_idle) && $past(cnt) == '0));
endmodule

// File: tb/krc_top_test.sv
`timescale 1ns/1ps
module krc_top_test;
  localparam int LAT = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic k_start, k_ready = 1'b0, k_done = 1'b0, k_idle = 1'b1;
  int total = 0, bad = 0, starts = 0, dones = 0, cyc = 0;
  bit busy = 0, prev_start = 0;
  int tmr = 0;

  always #5 clk = ~clk;

  krc_top uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .k_start(k_start), .k_ready(k_ready), .k_done(k_done), .k_idle(k_idle));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kernel model: accepts a start, finishes LAT cycles later with ready+done
  always @(negedge clk) begin
    cyc++;
    k_ready = 1'b0; k_done = 1'b0;
    if (rst_n && k_start) begin
      starts++;
      total++;
      if (busy || prev_start) begin
        bad++;
        $display("FAIL R7 actual=start_while_busy expected=no_start");
      end
      busy = 1; tmr = LAT;
    end else if (busy) begin
      if (tmr == 1) begin k_ready = 1'b1; k_done = 1'b1; busy = 0; dones++; end
      else tmr--;
    end
    prev_start = k_start;
    k_idle = !busy;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(string req, output bit got);
    logic [31:0] d;
    got = 0;
    for (int i = 0; i < 400 && !got; i++) begin
      rd(8'h00, d);
      if (d[1]) got = 1;
    end
    check(req, {31'd0, got}, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1", {31'd0, k_start}, 32'd0);
    rd(8'h10, d); check("R1", d, 32'd0);
    rd(8'h00, d); check("R1", d, 32'h04);
    rd(8'h04, d); check("R10", d, 32'd0);
  endtask

  task automatic t_counted();
    logic [31:0] d; bit got;
    starts = 0; dones = 0;
    wr(8'h10, 32'd3);
    rd(8'h10, d);
    total++;
    if (d > 32'd3 || d < 32'd2) begin bad++; $display("FAIL R2 actual=%0d expected=2..3", d); end
    rd(8'h00, d); check("R10", {31'd0, d[0]}, 32'd1);
    wait_flag("R5", got);
    check("R2", starts, 3);
    check("R5", dones, 3);
    rd(8'h00, d); check("R6", {31'd0, d[1]}, 32'd0);
    check("R10", {31'd0, d[2]}, 32'd1);
    idle_cycles(20); check("R2", starts, 3);
  endtask

  task automatic t_forever();
    logic [31:0] d; bit got; int s0;
    starts = 0; dones = 0;
    wr(8'h10, 32'hFFFF_FFFF);
    idle_cycles(60);
    total++;
    if (starts < 5) begin bad++; $display("FAIL R3 actual=%0d expected>=5", starts); end
    rd(8'h10, d); check("R3", d, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R5", {31'd0, d[1]}, 32'd0);
    wr(8'h10, 32'd0);
    rd(8'h10, d); check("R4", d, 32'd0);
    wait_flag("R4", got);
    s0 = starts;
    idle_cycles(30);
    check("R4", starts, s0);
    check("R4", dones, starts);
  endtask

  task automatic t_abort();
    logic [31:0] d; bit got; int s0;
    starts = 0; dones = 0;
    wr(8'h10, 32'd100);
    idle_cycles(20);
    wr(8'h10, 32'd0);
    rd(8'h10, d); check("R4", d, 32'd0);
    wait_flag("R4", got);
    s0 = starts;
    total++;
    if (s0 >= 100 || s0 < 2) begin bad++; $display("FAIL R4 actual=%0d expected=2..99", s0); end
    idle_cycles(30);
    check("R4", starts, s0);
    check("R4", dones, s0);
  endtask

  task automatic t_single();
    bit got;
    starts = 0; dones = 0;
    wr(8'h00, 32'h01);
    wait_flag("R9", got);
    idle_cycles(20);
    check("R9", starts, 1);
    check("R9", dones, 1);
  endtask

  task automatic t_legacy();
    logic [31:0] d; int s0;
    starts = 0; dones = 0;
    wr(8'h00, 32'h81);
    while (dones < 1) @(negedge clk);
    idle_cycles(1);
    rd(8'h00, d);
    check("R8", {31'd0, d[1]}, 32'd1);
    check("R10", {24'd0, d[7:0]} & 32'h81, 32'h81);
    s0 = dones;
    while (dones < s0 + 1) @(negedge clk);
    idle_cycles(1);
    rd(8'h00, d); check("R8", {31'd0, d[1]}, 32'd1);
    wr(8'h00, 32'h00);
    idle_cycles(10);
    s0 = starts;
    idle_cycles(30);
    check("R8", starts, s0);
    rd(8'h00, d);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    starts = 0; dones = 0;
    wr(8'h10, 32'd1);
    do @(posedge clk); while (!k_done);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h00;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    check("R6", {31'd0, d[1]}, 32'd0);
    rd(8'h00, d); check("R6", {31'd0, d[1]}, 32'd1);
    rd(8'h00, d); check("R6", {31'd0, d[1]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counted();
    t_forever();
    t_abort();
    t_single();
    t_legacy();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule